// File: doc/BRIEF.md
# PIC interrupt acknowledge sequencer

This block serves one legacy PIC-style interrupt controller on behalf of the system. When the PIC raises its request line, the block sends a vector query as a read to the interrupt-response region of the link's 40-bit address space. It then waits for the response, captures the returned vector number and records it as one bit in a 256-entry pending register. A per-vector mask register gates a single summary interrupt line toward the system interrupt controller.

Software services the vector and clears the pending bit through a write-1-to-clear port. It then sends the end-of-interrupt clear to the PIC itself and reports that with a one-cycle pulse. The block does not clear anything on its own, and it takes no new PIC request until that pulse has arrived.

Top module: `pic_ack_seq`

## Requirements
- R1: After reset `qry_valid_o` is 0, `pending_o` is all zero, `irq_o` is 0 and every mask bit is 1 (masked).
- R2: A high `pic_req_i` sampled while the sequencer is idle raises `qry_valid_o` after that clock edge. `qry_addr_o` reads 0xFD_F900_0000, and `qry_valid_o` stays high until a cycle in which `qry_ready_i` is high.
- R3: After the query is accepted, the block waits for `rsp_valid_i` and captures `rsp_vec_i` at that edge. `rsp_valid_i` has no effect while no query is outstanding.
- R4: The captured vector number v sets bit v of `pending_o` at the clock edge after the one that accepts the response. Only one bit is set per handshake.
- R5: After posting, the block ignores `pic_req_i` and issues no query until `eoi_done_i` is pulsed. A pulse of `eoi_done_i` at any other point has no effect.
- R6: The end-of-interrupt pulse does not clear any pending bit. There is no automatic clear.
- R7: When `clr_we_i` is high, every bit set to 1 in `clr_mask_i` is cleared in `pending_o` at the next edge. All other bits are unchanged.
- R8: If a vector is posted in the same cycle that a write-1-to-clear targets the same bit, the bit ends up set.
- R9: When `mask_we_i` is high, the mask register loads `mask_data_i` at the next edge. A mask bit of 1 blocks that vector from `irq_o`.
- R10: `irq_o` is the registered OR over all vectors of (pending AND NOT mask). It follows the pending and mask registers one cycle later.
- R11: Vector numbers 0 and 255, the two ends of the range, post to bits 0 and 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pic_req_i | input | 1 | Interrupt request level from the PIC |
| qry_valid_o | output | 1 | Vector query request valid |
| qry_addr_o | output | 40 | Query read address in the interrupt-response region |
| qry_ready_i | input | 1 | Query accepted |
| rsp_valid_i | input | 1 | Vector response valid |
| rsp_vec_i | input | 8 | Returned vector number |
| eoi_done_i | input | 1 | Pulse: software has sent the clear to the PIC |
| clr_we_i | input | 1 | Write-1-to-clear strobe for pending bits |
| clr_mask_i | input | 256 | Bits to clear in the pending register |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 256 | New mask value, 1 = masked |
| pending_o | output | 256 | Pending vector register |
| irq_o | output | 1 | Summary interrupt to the system interrupt controller |

## Verification
On every cycle the assertions check four things. A query is held until it is accepted and only follows a request. Each post sets its bit and happens once per handshake. A clear without a competing set empties the targeted bits. A fully masked or empty pending set drops the summary line. The bench scenarios are needed for the rest: the exact cycles at which the query, the pending bit and `irq_o` change, that the block blocks new requests until the end-of-interrupt pulse, that stray responses and stray end-of-interrupt pulses are ignored, the set-over-clear collision, and the vectors at both ends of the range.

// File: rtl/pic_ack_pkg.sv
package pic_ack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUERY,
    ST_WAIT_VEC,
    ST_POST,
    ST_WAIT_EOI
  } seq_state_e;
endpackage

// File: rtl/pic_ack_fsm.sv
module pic_ack_fsm
  import pic_ack_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pic_req_i,
  input  logic             qry_ready_i,
  input  logic             rsp_valid_i,
  input  logic [VEC_W-1:0] rsp_vec_i,
  input  logic             eoi_done_i,
  output logic             qry_valid_o,
  output logic             set_en_o,
  output logic [VEC_W-1:0] set_idx_o
);
  seq_state_e      state_q, state_d;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (pic_req_i)   state_d = ST_QUERY;
      ST_QUERY:    if (qry_ready_i) state_d = ST_WAIT_VEC;
      ST_WAIT_VEC: if (rsp_valid_i) state_d = ST_POST;
      ST_POST:                      state_d = ST_WAIT_EOI;
      ST_WAIT_EOI: if (eoi_done_i)  state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT_VEC && rsp_valid_i) vec_q <= rsp_vec_i;
    end
  end

  assign qry_valid_o = (state_q == ST_QUERY);
  assign set_en_o    = (state_q == ST_POST);
  assign set_idx_o   = vec_q;

  assert_query_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qry_valid_o && !qry_ready_i) |=> qry_valid_o);

  assert_query_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qry_valid_o) |-> $past(pic_req_i));

  assert_single_post_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_o |=> !set_en_o);

  assert_eoi_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_EOI && eoi_done_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pic_pending_reg.sv
module pic_pending_reg #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  logic [VEC_W-1:0]   set_idx_i,
  input  logic               clr_we_i,
  input  logic [NUM_VEC-1:0] clr_mask_i,
  output logic [NUM_VEC-1:0] pend_o
);
  logic [NUM_VEC-1:0] pend_q;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set_en_i && (set_idx_i == VEC_W'(i));
    assign hit_clr = clr_we_i && clr_mask_i[i];
    // set has priority so a vector arriving during a clear is kept
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_q[i] <= 1'b0;
      else if (hit_set) pend_q[i] <= 1'b1;
      else if (hit_clr) pend_q[i] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  assert_set_lands_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> pend_q[$past(set_idx_i)]);

  assert_clear_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_en_i) |=> ((pend_q & $past(clr_mask_i)) == '0));
endmodule

// File: rtl/pic_irq_summary.sv
module pic_irq_summary #(
  parameter int NUM_VEC = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [NUM_VEC-1:0] mask_data_i,
  input  logic [NUM_VEC-1:0] pend_i,
  output logic               irq_o
);
  logic [NUM_VEC-1:0] mask_q;
  logic               irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_data_i;
      irq_q <= |(pend_i & ~mask_q);
    end
  end

  assign irq_o = irq_q;

  assert_quiet_when_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~mask_q) == '0) |=> !irq_o);
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq #(
  parameter int              NUM_VEC    = 256,
  parameter int              ADDR_W     = 40,
  parameter logic [ADDR_W-1:0] QUERY_BASE = 40'hFD_F900_0000,
  localparam int             VEC_W      = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pic_req_i,
  output logic               qry_valid_o,
  output logic [ADDR_W-1:0]  qry_addr_o,
  input  logic               qry_ready_i,
  input  logic               rsp_valid_i,
  input  logic [VEC_W-1:0]   rsp_vec_i,
  input  logic               eoi_done_i,
  input  logic               clr_we_i,
  input  logic [NUM_VEC-1:0] clr_mask_i,
  input  logic               mask_we_i,
  input  logic [NUM_VEC-1:0] mask_data_i,
  output logic [NUM_VEC-1:0] pending_o,
  output logic               irq_o
);
  logic             set_en;
  logic [VEC_W-1:0] set_idx;

  pic_ack_fsm #(.VEC_W(VEC_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pic_req_i   (pic_req_i),
    .qry_ready_i (qry_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_vec_i   (rsp_vec_i),
    .eoi_done_i  (eoi_done_i),
    .qry_valid_o (qry_valid_o),
    .set_en_o    (set_en),
    .set_idx_o   (set_idx)
  );

  pic_pending_reg #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (set_en),
    .set_idx_i  (set_idx),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .pend_o     (pending_o)
  );

  pic_irq_summary #(.NUM_VEC(NUM_VEC)) u_sum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_we_i   (mask_we_i),
    .mask_data_i (mask_data_i),
    .pend_i      (pending_o),
    .irq_o       (irq_o)
  );

  assign qry_addr_o = QUERY_BASE;
endmodule

// File: tb/tb_pic_ack_seq.sv
module tb_pic_ack_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pic_req = 1'b0;
  logic         qry_valid;
  logic [39:0]  qry_addr;
  logic         qry_ready = 1'b0;
  logic         rsp_valid = 1'b0;
  logic [7:0]   rsp_vec = '0;
  logic         eoi_done = 1'b0;
  logic         clr_we = 1'b0;
  logic [255:0] clr_mask = '0;
  logic         mask_we = 1'b0;
  logic [255:0] mask_data = '0;
  logic [255:0] pending;
  logic         irq;

  logic [255:0] pend_m = '0;
  logic [255:0] mask_m = '1;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pic_ack_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .pic_req_i(pic_req),
    .qry_valid_o(qry_valid), .qry_addr_o(qry_addr), .qry_ready_i(qry_ready),
    .rsp_valid_i(rsp_valid), .rsp_vec_i(rsp_vec), .eoi_done_i(eoi_done),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask), .mask_we_i(mask_we),
    .mask_data_i(mask_data), .pending_o(pending), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic exp_irq();
    return |(pend_m & ~mask_m);
  endfunction

  task automatic t_reset();
    chk(qry_valid == 1'b0, "R1 qry_valid", 256'(qry_valid), 256'(0));
    chk(pending == '0, "R1 pending", pending, '0);
    chk(irq == 1'b0, "R1 irq", 256'(irq), 256'(0));
  endtask

  // full handshake for one vector; optional same-cycle clear of its bit
  task automatic t_ack(input logic [7:0] v, input bit collide);
    logic [255:0] b;
    b = 256'(1) << v;
    pic_req = 1'b1;
    step();
    chk(qry_valid == 1'b1, "R2 query raised", 256'(qry_valid), 256'(1));
    chk(qry_addr == 40'hFD_F900_0000, "R2 query addr", 256'(qry_addr), 256'(40'hFD_F900_0000));
    pic_req = 1'b0;
    step();
    chk(qry_valid == 1'b1, "R2 query held", 256'(qry_valid), 256'(1));
    qry_ready = 1'b1;
    step();
    qry_ready = 1'b0;
    chk(qry_valid == 1'b0, "R2 query dropped", 256'(qry_valid), 256'(0));
    eoi_done = 1'b1;       // stray pulse while waiting for the vector (R5)
    step();
    eoi_done = 1'b0;
    rsp_valid = 1'b1;
    rsp_vec = v;
    step();
    rsp_valid = 1'b0;
    rsp_vec = ~v;
    chk(pending == pend_m, "R4 not yet posted", pending, pend_m);
    if (collide) begin
      clr_we = 1'b1;
      clr_mask = b;
    end
    step();
    clr_we = 1'b0;
    clr_mask = '0;
    pend_m = pend_m | b;
    chk(pending == pend_m, collide ? "R8 set wins" : "R4 posted", pending, pend_m);
    step();
    chk(irq == exp_irq(), "R10 irq after post", 256'(irq), 256'(exp_irq()));
    pic_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk(qry_valid == 1'b0, "R5 blocked until eoi", 256'(qry_valid), 256'(0));
    end
    pic_req = 1'b0;
    eoi_done = 1'b1;
    step();
    eoi_done = 1'b0;
    chk(pending == pend_m, "R6 no auto clear", pending, pend_m);
    step();
  endtask

  task automatic t_mask(input logic [255:0] m);
    mask_we = 1'b1;
    mask_data = m;
    step();
    mask_we = 1'b0;
    mask_m = m;
    step();
    chk(irq == exp_irq(), "R9 irq after mask write", 256'(irq), 256'(exp_irq()));
  endtask

  task automatic t_unmask_latency(input logic [7:0] v);
    logic old;
    old = irq;
    mask_we = 1'b1;
    mask_data = ~(256'(1) << v);
    step();
    mask_we = 1'b0;
    mask_m = ~(256'(1) << v);
    chk(irq == old, "R10 one cycle latency", 256'(irq), 256'(old));
    step();
    chk(irq == exp_irq(), "R10 irq follows mask", 256'(irq), 256'(exp_irq()));
  endtask

  task automatic t_clear(input logic [255:0] m);
    logic old;
    old = irq;
    clr_we = 1'b1;
    clr_mask = m;
    step();
    clr_we = 1'b0;
    clr_mask = '0;
    pend_m = pend_m & ~m;
    chk(pending == pend_m, "R7 w1c", pending, pend_m);
    chk(irq == old, "R10 irq lags clear", 256'(irq), 256'(old));
    step();
    chk(irq == exp_irq(), "R10 irq after clear", 256'(irq), 256'(exp_irq()));
  endtask

  task automatic t_stray_rsp();
    rsp_valid = 1'b1;
    rsp_vec = 8'd9;
    step();
    rsp_valid = 1'b0;
    step();
    step();
    chk(pending == pend_m, "R3 stray response ignored", pending, pend_m);
    chk(qry_valid == 1'b0, "R3 no query from response", 256'(qry_valid), 256'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step();
    t_reset();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_ack(8'd37, 1'b0);
    chk(irq == 1'b0, "R9 default mask blocks", 256'(irq), 256'(0));
    t_unmask_latency(8'd37);
    t_clear((256'(1) << 37) | (256'(1) << 5));
    t_mask('0);
    t_ack(8'd0, 1'b0);
    t_ack(8'd255, 1'b0);
    chk(pending[0] && pending[255], "R11 range ends", pending, pend_m);
    t_ack(8'd200, 1'b1);
    t_clear((256'(1) << 0) | (256'(1) << 255));
    t_stray_rsp();
    t_mask(~(256'(1) << 201));
    t_mask(~(256'(1) << 200));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule